// File: doc/BRIEF.md
# Addend-Tuned Precision Time Counter

This block keeps a free-running precision time value as a 64-bit count of 32 ns ticks. On every reference clock a 32-bit fractional accumulator adds a programmable addend. Each carry out of the accumulator advances the time count by one. Software trims the clock rate by changing the addend. The default addend of 0xA0000000 gives one tick every 1.6 reference cycles, which is one tick per 32 ns at 50 MHz. Scaling the default by (1 ± ppb/1e9) gives a trim range of ±50,000,000 ppb. To get nanoseconds, shift the count left by five.

Software reaches the block through a small word-addressed register bus. Through it, software sets the control bits, the addend, the time value and a 64-bit target time. It also reads and clears an event register. When the time first reaches the target, the block raises a target-pending event. That event drives an interrupt line, which a control bit enables. A control bit also holds the whole counter in a software reset.

Top module: `tick_clock_core`

## Requirements
- R1: After reset the block holds these values, and `irq` is low.
  - Register map (bus index): control 0, event 1, addend 2, time low 3, time high 4, target low 5, target high 6.
  - Reset values: control reads 0, addend reads 0xA0000000, target low reads 1, target high reads 0.
- R2: On every clock the addend is added into the 32-bit accumulator, and a carry out adds exactly one to the time count. A load writes value T and clears the accumulator. After j further cycles the count is T + floor(j·A / 2^32).
- R3: A write to time low only stages the word. A write to time high loads {high, staged low} into the count in one step and clears the accumulator.
- R4: A read returns its data on `bus_rdata` one cycle after `bus_rd`. A read of time low returns the low word of the count at that edge and latches the high word. The next read of time high returns that latched word, even if the count has since carried into the high word.
- R5: While control bit 0 is 1, the block is in soft reset:
  - the count and the accumulator stay at 0;
  - the addend returns to 0xA0000000 and the target returns to 1;
  - writes to every register other than control are ignored.
- R6: Event bit 1 is the target-pending flag. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R7: Target pending sets one cycle after the first cycle in which count ≥ target. It does not set again while the count stays at or above the target.
- R8: `irq` is high exactly when target pending is set and control bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the accumulator steps once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Target-time interrupt request |

## Verification
A wrong accumulator or carry would shift the count read back from time low within a few cycles of a load, so the bench sweeps several addends over many delays after each load. A missing high-word latch shows as a torn high word when the load sits just below a carry into bit 32. A wrong compare or set/clear order would move the pending flag, and `irq`, by at least one cycle. The bench samples the edge where the flag must rise, and the cycles after a clear where it must stay low.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    localparam int DATA_W = 32;
    localparam int ACC_W  = 32;
    localparam int TIME_W = 64;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_EVENT   = 3'd1,
        REG_ADDEND  = 3'd2,
        REG_TIME_LO = 3'd3,
        REG_TIME_HI = 3'd4,
        REG_TGT_LO  = 3'd5,
        REG_TGT_HI  = 3'd6,
        REG_NONE    = 3'd7
    } reg_e;

    localparam logic [ACC_W-1:0]  ADDEND_RST = 32'hA000_0000;
    localparam logic [TIME_W-1:0] TGT_RST    = 64'd1;

    localparam int CTRL_SRST_BIT = 0;
    localparam int CTRL_TIE_BIT  = 1;
    localparam int EVT_TGT_BIT   = 1;

    typedef struct packed {
        logic              valid;
        logic [TIME_W-1:0] value;
    } time_load_t;

    function automatic logic [ACC_W:0] acc_step(input logic [ACC_W-1:0] acc,
                                                input logic [ACC_W-1:0] addend);
        return {1'b0, acc} + {1'b0, addend};
    endfunction
endpackage

// File: rtl/tcc_accum.sv
module tcc_accum
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic [ACC_W-1:0]  addend,
    input  time_load_t        load,
    output logic [TIME_W-1:0] time_q
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = acc_step(acc_q, addend);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            acc_q  <= '0;
            time_q <= '0;
        end else if (load.valid) begin
            acc_q  <= '0;
            time_q <= load.value;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            time_q <= time_q + {{(TIME_W-1){1'b0}}, sum[ACC_W]};
        end
    end
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic [TIME_W-1:0] time_q,
    input  logic [TIME_W-1:0] tgt,
    input  logic              clr,
    output logic              pend
);
    logic hit;
    logic hit_q;

    assign hit = (time_q >= tgt);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            hit_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            hit_q <= hit;
            if (hit && !hit_q)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/tcc_regs.sv
module tcc_regs
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_q,
    input  logic              pend,
    output logic [DATA_W-1:0] rdata,
    output logic              srst,
    output logic              tie,
    output logic [ACC_W-1:0]  addend,
    output logic [TIME_W-1:0] tgt,
    output time_load_t        load,
    output logic              evt_clr
);
    localparam int HALF = TIME_W / 2;

    reg_e            sel;
    logic [1:0]      ctrl_q;
    logic [HALF-1:0] stage_lo;
    logic [HALF-1:0] hi_latch;
    logic [DATA_W-1:0] rd_mux;

    assign sel  = reg_e'(addr);
    assign srst = ctrl_q[CTRL_SRST_BIT];
    assign tie  = ctrl_q[CTRL_TIE_BIT];

    assign load.valid = wr && (sel == REG_TIME_HI) && !srst;
    assign load.value = {wdata, stage_lo};
    assign evt_clr    = wr && (sel == REG_EVENT) && wdata[EVT_TGT_BIT] && !srst;

    always_comb begin
        rd_mux = '0;
        case (sel)
            REG_CTRL:    rd_mux = {{(DATA_W-2){1'b0}}, ctrl_q};
            REG_EVENT:   rd_mux[EVT_TGT_BIT] = pend;
            REG_ADDEND:  rd_mux = addend;
            REG_TIME_LO: rd_mux = time_q[HALF-1:0];
            REG_TIME_HI: rd_mux = hi_latch;
            REG_TGT_LO:  rd_mux = tgt[HALF-1:0];
            REG_TGT_HI:  rd_mux = tgt[TIME_W-1:HALF];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            addend   <= ADDEND_RST;
            tgt      <= TGT_RST;
            stage_lo <= '0;
            hi_latch <= '0;
            rdata    <= '0;
        end else begin
            if (wr && sel == REG_CTRL)
                ctrl_q <= wdata[1:0];
            if (srst) begin
                addend   <= ADDEND_RST;
                tgt      <= TGT_RST;
                stage_lo <= '0;
                hi_latch <= '0;
            end else if (wr) begin
                case (sel)
                    REG_ADDEND:  addend   <= wdata;
                    REG_TIME_LO: stage_lo <= wdata;
                    REG_TGT_LO:  tgt[HALF-1:0]      <= wdata;
                    REG_TGT_HI:  tgt[TIME_W-1:HALF] <= wdata;
                    default: ;
                endcase
            end
            if (rd) begin
                rdata <= rd_mux;
                if (sel == REG_TIME_LO && !srst)
                    hi_latch <= time_q[TIME_W-1:HALF];
            end
        end
    end
endmodule

// File: rtl/tick_clock_core.sv
module tick_clock_core
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              srst;
    logic              tie;
    logic [ACC_W-1:0]  addend;
    logic [TIME_W-1:0] tgt;
    logic [TIME_W-1:0] time_q;
    time_load_t        load;
    logic              evt_clr;
    logic              pend;

    tcc_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .time_q(time_q), .pend(pend), .rdata(bus_rdata),
        .srst(srst), .tie(tie), .addend(addend), .tgt(tgt), .load(load),
        .evt_clr(evt_clr)
    );

    tcc_accum u_accum (
        .clk(clk), .rst(rst), .srst(srst), .addend(addend), .load(load),
        .time_q(time_q)
    );

    tcc_compare u_cmp (
        .clk(clk), .rst(rst), .srst(srst), .time_q(time_q), .tgt(tgt),
        .clr(evt_clr), .pend(pend)
    );

    assign irq = pend & tie;
endmodule

// File: rtl/tick_clock_core_chk.sv
module tick_clock_core_chk
    import tcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              srst,
    input logic              tie,
    input logic              load_valid,
    input logic              clr,
    input logic [ACC_W-1:0]  addend,
    input logic [TIME_W-1:0] time_q,
    input logic [TIME_W-1:0] tgt,
    input logic              pend,
    input logic              irq
);
    // R5: soft reset holds the count at zero
    a_r5_srst_zero: assert property (@(posedge clk) disable iff (rst)
        srst |=> (time_q == '0));

    // R5: soft reset restores the default addend
    a_r5_srst_addend: assert property (@(posedge clk) disable iff (rst)
        srst |=> (addend == ADDEND_RST));

    // R2: without a load the count moves by at most one per cycle
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (!srst && !load_valid) |=> ((time_q - $past(time_q)) <= 64'd1));

    // R7: pending only rises after the count reached the target
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(time_q >= tgt));

    // R6: pending only falls on a clear or a soft reset
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> ($past(clr) || $past(srst)));

    // R8: no interrupt while the enable bit is low
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
        !tie |-> !irq);
endmodule

bind tick_clock_core tick_clock_core_chk u_chk (
    .clk(clk), .rst(rst), .srst(srst), .tie(tie), .load_valid(load.valid),
    .clr(evt_clr), .addend(addend), .time_q(time_q), .tgt(tgt), .pend(pend),
    .irq(irq)
);

// File: tb/tick_clock_core_tb.sv
module tick_clock_core_tb;
    import tcc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_clock_core u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // all tasks start and end at a falling edge
    task automatic wr(input reg_e a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input reg_e a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] adds [5];
        logic [63:0] t0;
        logic [63:0] exp_t;
        adds[0] = 32'hA000_0000; adds[1] = 32'h8000_0000; adds[2] = 32'hFFFF_FFFF;
        adds[3] = 32'h1234_5678; adds[4] = 32'hA00A_7C5B;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(REG_CTRL, d);   check("R1 ctrl", d, 0);
        rd(REG_ADDEND, d); check("R1 addend", d, 32'hA000_0000);
        rd(REG_TGT_LO, d); check("R1 tgt_lo", d, 1);
        rd(REG_TGT_HI, d); check("R1 tgt_hi", d, 0);
        check("R1 irq", irq, 0);

        // R2 R3 R4 sweep of addends and delays after a load
        t0 = 64'h0000_0007_FFFF_FFF8;
        for (int a = 0; a < 5; a++) begin
            for (int j = 0; j < 16; j++) begin
                wr(REG_ADDEND, adds[a]);
                wr(REG_TIME_LO, t0[31:0]);
                wr(REG_TIME_HI, t0[63:32]);
                idle(j);
                rd(REG_TIME_LO, lo);
                rd(REG_TIME_HI, hi);
                exp_t = t0 + ((64'(j) * 64'(adds[a])) >> 32);
                check("R2 R3 time_lo", lo, exp_t[31:0]);
                check("R4 latched time_hi", hi, exp_t[63:32]);
            end
        end

        // R5 soft reset
        wr(REG_CTRL, 32'h1);
        wr(REG_ADDEND, 32'h0000_1234);
        wr(REG_TGT_LO, 32'h55);
        wr(REG_TIME_LO, 32'h77);
        wr(REG_TIME_HI, 32'h1);
        rd(REG_ADDEND, d);  check("R5 addend ignored", d, 32'hA000_0000);
        rd(REG_TGT_LO, d);  check("R5 tgt default", d, 1);
        idle(4);
        rd(REG_TIME_LO, d); check("R5 time held", d, 0);

        // R7 R8 target event timing
        wr(REG_CTRL, 32'h2);
        wr(REG_ADDEND, 32'h8000_0000);
        wr(REG_TGT_LO, 32'd103);
        wr(REG_TGT_HI, 32'd0);
        wr(REG_TIME_LO, 32'd100);
        wr(REG_TIME_HI, 32'd0);
        idle(6);
        check("R7 not yet pending", irq, 0);
        idle(1);
        check("R7 R8 pending irq", irq, 1);
        rd(REG_EVENT, d);   check("R7 event bit", d, 32'h2);

        // R6 write of 0 does not clear
        wr(REG_EVENT, 32'h0);
        rd(REG_EVENT, d);   check("R6 zero write kept", d, 32'h2);

        // R8 enable gating
        wr(REG_CTRL, 32'h0);
        check("R8 irq masked", irq, 0);
        rd(REG_EVENT, d);   check("R8 pending kept", d, 32'h2);
        wr(REG_CTRL, 32'h2);
        check("R8 irq enabled", irq, 1);

        // R6 clear, R7 no re-set while above target
        wr(REG_EVENT, 32'h2);
        check("R6 cleared irq", irq, 0);
        rd(REG_EVENT, d);   check("R6 event cleared", d, 0);
        idle(5);
        check("R7 no re-set", irq, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule